// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from the moment reset is released until the memory is ready for normal traffic. It first holds the device quiet: clock enable and data mask stay high and only NOP commands go out for the stable-power interval. That interval is given in microseconds and converted to clock cycles from the clock frequency parameter. It then precharges both banks and issues a parameterised number of auto-refresh commands. It also loads the mode register and the extended mode register. Each register opcode is assembled from field inputs held steady by the system.

Every command is followed by its own minimum gap before the next one. The gap after precharge is the precharge time, the gap after a refresh is the row cycle time, and the gap after a register load is the load-to-command time. A parameter selects whether the refresh group or the register-load group comes first after the precharge. When the sequence is complete the block raises `done`. It keeps `done` high and drives NOP until the next reset, so that a normal controller can take over the pins.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset, and for exactly CLK_MHZ*WAIT_US cycles after reset is released, the command is NOP, which is cs_n=0, ras_n=1, cas_n=1 and we_n=1.
- R2: In the cycle after the wait, a precharge-all is issued: ras_n=0, cas_n=1, we_n=0, with addr[10]=1.
- R3: After the precharge, exactly TRP_CYC-1 NOP cycles follow, so the next command comes TRP_CYC cycles after the precharge.
- R4: Exactly REFRESHES auto-refresh commands are issued, encoded as ras_n=0, cas_n=0 and we_n=1. Consecutive commands after a refresh are spaced TRC_CYC cycles apart.
- R5: The mode register load has all four strobes low and ba=0. Its addr carries the burst length in [2:0], interleave in [3], CAS latency in [6:4] and single-write in [9], with every other bit at 0. It is issued only after the precharge.
- R6: The extended register load has all four strobes low and ba=1. Its addr carries array coverage in [2:0], temperature in [4:3] and drive strength in [6:5], with bits [10:7] at 0.
- R7: The mode register load comes first and the extended load follows TMRD_CYC cycles later. The next command, or `done`, comes TMRD_CYC cycles after the extended load.
- R8: `done` rises exactly one gap after the last command of the sequence, stays high until reset, and only NOP is driven while it is high.
- R9: With LOADS_FIRST=0, the order is precharge, refreshes, then loads. With LOADS_FIRST=1, the order is precharge, loads, then refreshes.
- R10: cke and dqm are high in every cycle, both during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_burst_len | input | 3 | Burst length code for the mode register |
| mr_interleave | input | 1 | Burst type for the mode register (1 = interleave) |
| mr_cas_lat | input | 3 | CAS latency code for the mode register |
| mr_single_write | input | 1 | Burst-read single-write enable |
| emr_array_cov | input | 3 | Self-refresh array coverage code |
| emr_temp | input | 2 | Temperature range code |
| emr_drive | input | 2 | Output drive strength code |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| ba | output | 1 | Bank / register select |
| addr | output | 11 | Address / opcode |
| dqm | output | 1 | Data mask |
| done | output | 1 | Initialization complete |

## Verification
The assertions assume that every gap parameter is at least 2 cycles and that REFRESHES is at least 2. Under those conditions no two commands can fall in adjacent cycles, and every gap check can be measured against the previous command. They also assume the opcode field inputs are stable throughout a run. The bench therefore draws new field values only while reset is held, using a fixed-seed generator mixed with all-zero and all-one directed patterns. Both order variants are built with gap values that meet these limits.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ     = 100,
  parameter int WAIT_US     = 200,
  parameter int TRP_CYC     = 3,
  parameter int TRC_CYC     = 9,
  parameter int TMRD_CYC    = 2,
  parameter int REFRESHES   = 2,
  parameter bit LOADS_FIRST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mr_burst_len,
  input  logic        mr_interleave,
  input  logic [2:0]  mr_cas_lat,
  input  logic        mr_single_write,
  input  logic [2:0]  emr_array_cov,
  input  logic [1:0]  emr_temp,
  input  logic [1:0]  emr_drive,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic        ba,
  output logic [10:0] addr,
  output logic        dqm,
  output logic        done
);

  localparam int PWR_CYC = CLK_MHZ * WAIT_US;
  localparam int GAP_MAX = (TRC_CYC > TRP_CYC) ? ((TRC_CYC > TMRD_CYC) ? TRC_CYC : TMRD_CYC)
                                               : ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC);
  localparam int CNT_MAX = (PWR_CYC > GAP_MAX) ? PWR_CYC : GAP_MAX;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int RW      = $clog2(REFRESHES + 1);

  typedef enum logic [3:0] {
    RESET_WAIT, PRECHARGE, TRP_WAIT, REFRESH, TRC_WAIT,
    LOAD_MR, LOAD_EMR, TMRD_WAIT, DONE
  } seq_t;

  seq_t          st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] refs;
  logic          emr_loaded;
  logic          expired;

  assign expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= RESET_WAIT;
      cnt        <= CW'(PWR_CYC - 1);
      refs       <= '0;
      emr_loaded <= 1'b0;
    end else begin
      case (st)
        RESET_WAIT: begin
          if (expired) st <= PRECHARGE;
          else         cnt <= cnt - 1'b1;
        end
        PRECHARGE: begin
          st  <= TRP_WAIT;
          cnt <= CW'(TRP_CYC - 2);
        end
        TRP_WAIT: begin
          if (expired) st <= LOADS_FIRST ? LOAD_MR : REFRESH;
          else         cnt <= cnt - 1'b1;
        end
        REFRESH: begin
          st   <= TRC_WAIT;
          cnt  <= CW'(TRC_CYC - 2);
          refs <= refs + 1'b1;
        end
        TRC_WAIT: begin
          if (!expired)                     cnt <= cnt - 1'b1;
          else if (refs != RW'(REFRESHES))  st  <= REFRESH;
          else if (LOADS_FIRST)             st  <= DONE;
          else                              st  <= LOAD_MR;
        end
        LOAD_MR: begin
          st  <= TMRD_WAIT;
          cnt <= CW'(TMRD_CYC - 2);
        end
        LOAD_EMR: begin
          st         <= TMRD_WAIT;
          cnt        <= CW'(TMRD_CYC - 2);
          emr_loaded <= 1'b1;
        end
        TMRD_WAIT: begin
          if (!expired)        cnt <= cnt - 1'b1;
          else if (!emr_loaded) st <= LOAD_EMR;
          else if (LOADS_FIRST) st <= REFRESH;
          else                  st <= DONE;
        end
        DONE:    st <= DONE;
        default: st <= RESET_WAIT;
      endcase
    end
  end

  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ba    = 1'b0;
    addr  = '0;
    case (st)
      PRECHARGE: begin
        ras_n    = 1'b0;
        we_n     = 1'b0;
        addr[10] = 1'b1;
      end
      REFRESH: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      LOAD_MR: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        addr  = {1'b0, mr_single_write, 2'b00, mr_cas_lat, mr_interleave, mr_burst_len};
      end
      LOAD_EMR: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        ba    = 1'b1;
        addr  = {4'b0000, emr_drive, emr_temp, emr_array_cov};
      end
      default: ;
    endcase
  end

  assign cke  = 1'b1;
  assign dqm  = 1'b1;
  assign done = (st == DONE);

  logic          cmd_on, is_load, is_pre, is_ref;
  logic          any_cmd, pre_seen;
  logic [CW-1:0] since, need;
  logic [RW-1:0] refs_seen;

  assign cmd_on  = !(ras_n && cas_n && we_n);
  assign is_load = !ras_n && !cas_n && !we_n;
  assign is_pre  = !ras_n && cas_n && !we_n;
  assign is_ref  = !ras_n && !cas_n && we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_cmd   <= 1'b0;
      pre_seen  <= 1'b0;
      since     <= '0;
      need      <= '0;
      refs_seen <= '0;
    end else begin
      if (cmd_on) begin
        any_cmd <= 1'b1;
        since   <= CW'(1);
        need    <= is_pre ? CW'(TRP_CYC) : is_ref ? CW'(TRC_CYC) : CW'(TMRD_CYC);
      end else if (since != CW'(CNT_MAX)) begin
        since <= since + 1'b1;
      end
      if (is_pre) pre_seen  <= 1'b1;
      if (is_ref) refs_seen <= refs_seen + 1'b1;
    end
  end

  AST_CMD_SPACING:   assert property (@(posedge clk) disable iff (!rst_n) (cmd_on && any_cmd) |-> since >= need); // R7
  AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (!rst_n) cmd_on |=> !cmd_on); // R3
  AST_LOAD_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) is_load |-> pre_seen); // R5
  AST_REF_TOTAL:     assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> refs_seen == RW'(REFRESHES)); // R4
  AST_DONE_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R8
  AST_DONE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !cmd_on); // R8

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

  localparam int P   = 13;
  localparam int TRP = 3, TRC = 5, TM = 2, N = 3;
  localparam int TRP2 = 2, TRC2 = 4, TM2 = 3, N2 = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bl = '0, cl = '0, cov = '0;
  logic bt = 1'b0, sw = 1'b0;
  logic [1:0] tmp = '0, drv = '0;

  logic cke_a, cs_a, ras_a, cas_a, we_a, ba_a, dqm_a, done_a;
  logic cke_b, cs_b, ras_b, cas_b, we_b, ba_b, dqm_b, done_b;
  logic [10:0] addr_a, addr_b;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(1), .WAIT_US(P), .TRP_CYC(TRP), .TRC_CYC(TRC),
    .TMRD_CYC(TM), .REFRESHES(N), .LOADS_FIRST(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .mr_burst_len(bl), .mr_interleave(bt), .mr_cas_lat(cl),
    .mr_single_write(sw), .emr_array_cov(cov), .emr_temp(tmp), .emr_drive(drv),
    .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a), .ba(ba_a),
    .addr(addr_a), .dqm(dqm_a), .done(done_a));

  sdram_init_seq #(.CLK_MHZ(1), .WAIT_US(P), .TRP_CYC(TRP2), .TRC_CYC(TRC2),
    .TMRD_CYC(TM2), .REFRESHES(N2), .LOADS_FIRST(1'b1)) uut_swap (
    .clk(clk), .rst_n(rst_n), .mr_burst_len(bl), .mr_interleave(bt), .mr_cas_lat(cl),
    .mr_single_write(sw), .emr_array_cov(cov), .emr_temp(tmp), .emr_drive(drv),
    .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b), .ba(ba_b),
    .addr(addr_b), .dqm(dqm_b), .done(done_b));

  // codes: 0 NOP, 1 precharge, 2 refresh, 3 mode load, 4 extended load, 7 other
  function automatic int dec(logic cs, logic ras, logic cas, logic we, logic b);
    if (cs) return 7;
    if (ras && cas && we) return 0;
    if (!ras && cas && !we) return 1;
    if (!ras && !cas && we) return 2;
    if (!ras && !cas && !we) return b ? 4 : 3;
    return 7;
  endfunction

  function automatic int exp_code(int k, int trp, int trc, int m, int n, bit lf);
    int t;
    if (k < P) return 0;
    if (k == P) return 1;
    t = k - P - trp;
    if (t < 0) return 0;
    if (!lf) begin
      if (t < n * trc) return (t % trc == 0) ? 2 : 0;
      t = t - n * trc;
      if (t == 0) return 3;
      if (t == m) return 4;
      return 0;
    end
    if (t == 0) return 3;
    if (t == m) return 4;
    if (t < 2 * m) return 0;
    t = t - 2 * m;
    if (t < n * trc) return (t % trc == 0) ? 2 : 0;
    return 0;
  endfunction

  function automatic int end_cyc(int trp, int trc, int m, int n);
    return P + trp + n * trc + 2 * m;
  endfunction

  function automatic string tag(int k, int code, int trp, int e, bit lf);
    if (lf) return "R9";
    if (k < P) return "R1";
    if (code == 1) return "R2";
    if (code == 2) return "R4";
    if (code == 3) return "R5";
    if (code == 4) return "R6";
    if (k <= P + trp) return "R3";
    if (k >= e) return "R8";
    return "R7";
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, act, expv);
    end
  endtask

  task automatic check_inst(int k, int code, logic [10:0] a, logic d, logic ck, logic dm,
                            int trp, int trc, int m, int n, bit lf);
    int e, want;
    e = end_cyc(trp, trc, m, n);
    want = exp_code(k, trp, trc, m, n, lf);
    chk(code == want, tag(k, want, trp, e, lf), code, want);
    chk(d == (k >= e), "R8", int'(d), int'(k >= e));
    chk(ck && dm, "R10", int'({ck, dm}), 3);
    if (want == 1) chk(a[10] == 1'b1, "R2", int'(a), 11'h400);
    if (want == 3) chk(a == {1'b0, sw, 2'b00, cl, bt, bl}, "R5", int'(a), int'({1'b0, sw, 2'b00, cl, bt, bl}));
    if (want == 4) chk(a == {4'b0, drv, tmp, cov}, "R6", int'(a), int'({4'b0, drv, tmp, cov}));
  endtask

  task automatic run_trial(int kind);
    int e_max;
    @(negedge clk);
    rst_n = 1'b0;
    if (kind == 0) begin
      {bl, bt, cl, sw, cov, tmp, drv} = '0;
    end else if (kind == 1) begin
      {bl, bt, cl, sw, cov, tmp, drv} = '1;
    end else begin
      bl = 3'($urandom); bt = 1'($urandom); cl = 3'($urandom); sw = 1'($urandom);
      cov = 3'($urandom); tmp = 2'($urandom); drv = 2'($urandom);
    end
    repeat (3) @(negedge clk);
    cyc = -1;
    chk(dec(cs_a, ras_a, cas_a, we_a, ba_a) == 0 && !done_a, "R1", int'(done_a), 0);
    chk(cke_a && dqm_a && cke_b && dqm_b, "R10", int'({cke_a, dqm_a, cke_b, dqm_b}), 15);
    rst_n = 1'b1;
    e_max = end_cyc(TRP, TRC, TM, N) + 6;
    for (int k = 0; k < e_max; k++) begin
      cyc = k;
      check_inst(k, dec(cs_a, ras_a, cas_a, we_a, ba_a), addr_a, done_a, cke_a, dqm_a,
                 TRP, TRC, TM, N, 1'b0);
      check_inst(k, dec(cs_b, ras_b, cas_b, we_b, ba_b), addr_b, done_b, cke_b, dqm_b,
                 TRP2, TRC2, TM2, N2, 1'b1);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int t = 0; t < 8; t++) run_trial(t);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int w = 0; w < 20000; w++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule